// File: doc/BRIEF.md
# 64-bit Interval Timer with Atomic Counter Readout

This block is a memory-mapped interval timer for a processor subsystem. A 64-bit up-counter advances on prescaled ticks taken from one of two tick-enable inputs. One input stands for the peripheral clock and the other for a slower secondary clock, whose rate must not exceed one third of the peripheral rate. When the counter reaches a programmed 64-bit period, the block raises a pending flag. In continuous operation the counter wraps and keeps running. In one-shot operation it halts until software starts it again.

Software reaches the block over a simple word-wide register bus, 32 bits wide by default. Because the period and the counter are twice the bus width, each is split into a low and a high word. The period is applied only as a whole, on the low-word write. The counter is read atomically: a low-word read captures the high half into a shadow register, and the next high-word read returns that capture. Reading the status register returns the pending flag and clears it. The interrupt line is the pending flag gated by its enable bit, and it stays high until the status register is read.

A typical setup sequence is: software reset, mode, period high word, period low word, interrupt enable, then start.

Top module: `ivt_timer`

## Requirements
- R1: Registers sit at byte offsets control 0x00, mode 0x04, period low 0x08, period high 0x0C, interrupt enable 0x10, status 0x1C, counter low 0x20 and counter high 0x24. A read returns its data on `bus_rdata` one clock after the read cycle. Mode reads back only bit 0 (continuous), bit 3 (secondary source) and bits 11:8 (prescaler). After reset, mode, enable, status and control read as 0, and the period reads as all ones.
- R2: A write to period high only stages the value. The whole period, staged high word plus written low word, takes effect on the period low write, so reading period high before that write still shows the old value.
- R3: Writing control with bit 0 set starts the counter from zero. Writing control with bit 8 set is a software reset: it clears the counter, the prescaler phase, the running state and the pending flag, and it wins when both bits are set. Mode, period and enable are kept. Control bit 0 reads back the running state.
- R4: The selected tick is divided by P+1, where P is mode bits 11:8. After a start, the counter holds floor(k/(P+1)) after k consecutive ticks.
- R5: Mode bit 3 = 1 selects `tick_sec`, and 0 selects `tick_per`. Ticks on the input that is not selected have no effect on the counter.
- R6: On an advance with the counter equal to the period, the pending flag is set. In continuous mode (mode bit 0 = 1) the counter returns to zero, so one period spans period+1 advances.
- R7: In one-shot mode (mode bit 0 = 0), the counter stops at the period value with the running state cleared. A new start counts again from zero.
- R8: Reading status returns the pending flag in bit 0 and clears it. A new period hit in the same cycle keeps the flag set.
- R9: `irq` is high exactly while the pending flag and enable bit 0 are both 1.
- R10: A counter low read captures the counter's high half. A later counter high read returns that captured value, however many cycles lie between the two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_per | input | 1 | Peripheral-clock tick enable |
| tick_sec | input | 1 | Secondary-clock tick enable, at most one in three cycles |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level period interrupt |

## Verification
The hardest case to reach is a carry into the counter's upper half falling between a low-word read and the matching high-word read, because with a full 32-bit word that carry needs billions of ticks. The bench therefore builds the block with a 16-bit word. It starts the counter with an all-ones period and ticks every cycle. It waits until the low half is just below its roll-over, reads the low word, waits past the carry, and then checks that the high read still returns the captured zero while a fresh read pair returns one. Exact cycle counting after each start write gives exact expected counts for the prescaler, wrap and one-shot stop checks.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // byte offsets of the register window
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_MODE = 'h04;
  localparam int OFS_PLO  = 'h08;
  localparam int OFS_PHI  = 'h0C;
  localparam int OFS_IEN  = 'h10;
  localparam int OFS_STAT = 'h1C;
  localparam int OFS_CLO  = 'h20;
  localparam int OFS_CHI  = 'h24;

  // field positions
  localparam int B_START  = 0;
  localparam int B_SWRST  = 8;
  localparam int B_CONT   = 0;
  localparam int B_SEL    = 3;
  localparam int B_PRE_LO = 8;
  localparam int PRE_W    = 4;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic             sel;
    logic             cont;
  } mode_t;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             sel_b,
  input  logic [PRE_W-1:0] presc,
  input  logic             run,
  input  logic             restart,
  output logic             adv
);
  logic [PRE_W-1:0] phase;
  logic             tick;

  always_comb begin
    tick = sel_b ? tick_b : tick_a;
    adv  = run & tick & (phase == presc);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
    end else if (run && tick) begin
      phase <= adv ? '0 : phase + 1'b1;
    end
  end

  // R4: between terminal counts the phase steps by one per selected tick
  assert_phase_step_R4: assert property (@(posedge clk) disable iff (rst)
    (run && tick && (phase != presc) && !restart) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             start,
  input  logic             swrst,
  input  logic             cont,
  input  logic [CNT_W-1:0] period,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             flag
);
  logic hit;

  always_comb hit = running & adv & (count == period) & ~start;

  always_ff @(posedge clk) begin
    if (rst || swrst) begin
      count   <= '0;
      running <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (start) begin
        count   <= '0;
        running <= 1'b1;
      end else if (running && adv) begin
        if (count == period) begin
          if (cont) count   <= '0;
          else      running <= 1'b0;
        end else begin
          count <= count + 1'b1;
        end
      end
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R3: software reset leaves the counter idle and clean
  assert_swrst_clears_R3: assert property (@(posedge clk) disable iff (rst)
    swrst |=> (count == '0 && !running && !flag));
  // R6: continuous wrap goes to zero with the flag raised
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && cont && !swrst) |=> (count == '0 && flag && running));
  // R7: one-shot halts at the period
  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && !cont && !swrst) |=> (!running && count == $past(period)));
  // R8: a status read with no new hit leaves the flag clear
  assert_status_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag);
endmodule

// File: rtl/ivt_regfile.sv
module ivt_regfile
  import ivt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output mode_t             mode,
  output logic [CNT_W-1:0]  period,
  output logic              irq_en,
  output logic              start_p,
  output logic              swrst_p,
  output logic              stat_rd,
  input  logic [CNT_W-1:0]  count,
  input  logic              running,
  input  logic              flag
);
  logic              wr_en, rd_en;
  logic              is_ctrl, is_mode, is_plo, is_phi, is_ien, is_stat, is_clo, is_chi;
  logic [DATA_W-1:0] stage;
  logic [DATA_W-1:0] shadow;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_en   = bus_sel & bus_wr;
    rd_en   = bus_sel & ~bus_wr;
    is_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    is_mode = (bus_addr == ADDR_W'(OFS_MODE));
    is_plo  = (bus_addr == ADDR_W'(OFS_PLO));
    is_phi  = (bus_addr == ADDR_W'(OFS_PHI));
    is_ien  = (bus_addr == ADDR_W'(OFS_IEN));
    is_stat = (bus_addr == ADDR_W'(OFS_STAT));
    is_clo  = (bus_addr == ADDR_W'(OFS_CLO));
    is_chi  = (bus_addr == ADDR_W'(OFS_CHI));
    swrst_p = wr_en & is_ctrl & bus_wdata[B_SWRST];
    start_p = wr_en & is_ctrl & bus_wdata[B_START] & ~bus_wdata[B_SWRST];
    stat_rd = rd_en & is_stat;
  end

  always_comb begin
    rd_mux = '0;
    if (is_ctrl) rd_mux[B_START] = running;
    if (is_mode) begin
      rd_mux[B_CONT]               = mode.cont;
      rd_mux[B_SEL]                = mode.sel;
      rd_mux[B_PRE_LO +: PRE_W]    = mode.presc;
    end
    if (is_plo)  rd_mux = period[DATA_W-1:0];
    if (is_phi)  rd_mux = period[CNT_W-1:DATA_W];
    if (is_ien)  rd_mux[0] = irq_en;
    if (is_stat) rd_mux[0] = flag;
    if (is_clo)  rd_mux = count[DATA_W-1:0];
    if (is_chi)  rd_mux = shadow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= '0;
      period    <= '1;
      stage     <= '0;
      irq_en    <= 1'b0;
      shadow    <= '0;
      bus_rdata <= '0;
    end else begin
      if (rd_en) bus_rdata <= rd_mux;
      if (rd_en && is_clo) shadow <= count[CNT_W-1:DATA_W];
      if (wr_en) begin
        if (is_mode) begin
          mode.cont  <= bus_wdata[B_CONT];
          mode.sel   <= bus_wdata[B_SEL];
          mode.presc <= bus_wdata[B_PRE_LO +: PRE_W];
        end
        if (is_phi) stage  <= bus_wdata;
        if (is_plo) period <= {stage, bus_wdata};
        if (is_ien) irq_en <= bus_wdata[0];
      end
    end
  end

  // R2: a high-word write alone never changes the live period
  assert_period_whole_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_phi) |=> $stable(period));
  // R10: a low-word counter read captures the high half
  assert_shadow_capture_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_clo) |=> (shadow == $past(count[CNT_W-1:DATA_W])));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_per,
  input  logic              tick_sec,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  mode_t             mode;
  logic [CNT_W-1:0]  period, count;
  logic              irq_en, start_p, swrst_p, stat_rd;
  logic              running, flag, adv;

  ivt_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode(mode), .period(period), .irq_en(irq_en),
    .start_p(start_p), .swrst_p(swrst_p), .stat_rd(stat_rd),
    .count(count), .running(running), .flag(flag)
  );

  ivt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst),
    .tick_a(tick_per), .tick_b(tick_sec), .sel_b(mode.sel),
    .presc(mode.presc), .run(running),
    .restart(start_p | swrst_p), .adv(adv)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .adv(adv),
    .start(start_p), .swrst(swrst_p), .cont(mode.cont),
    .period(period), .clr(stat_rd),
    .count(count), .running(running), .flag(flag)
  );

  // both operands are flops; the line is a single gate past them
  assign irq = flag & irq_en;

  // R9: after a status read with nothing pending the line is low
  assert_irq_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !adv && !swrst_p) |=> !irq);
endmodule

// File: tb/ivt_timer_test.sv
`timescale 1ns/1ps
module ivt_timer_test;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int TW = 1 + 8 + DW + DW;
  localparam int NV = 16;

  // {write, addr, data, expected read}
  localparam logic [TW-1:0] VEC [NV] = '{
    {1'b0, 8'h04, 16'h0000, 16'h0000},  // R1 mode reset
    {1'b0, 8'h00, 16'h0000, 16'h0000},  // R1 control reset
    {1'b0, 8'h10, 16'h0000, 16'h0000},  // R1 enable reset
    {1'b0, 8'h1C, 16'h0000, 16'h0000},  // R1 status reset
    {1'b0, 8'h08, 16'h0000, 16'hFFFF},  // R1 period low reset
    {1'b1, 8'h04, 16'h0309, 16'h0000},  // R1 mode write
    {1'b0, 8'h04, 16'h0000, 16'h0309},  // R1 mode readback
    {1'b1, 8'h04, 16'hFFF7, 16'h0000},  // R1 only defined bits
    {1'b0, 8'h04, 16'h0000, 16'h0F01},  // R1
    {1'b1, 8'h0C, 16'h0012, 16'h0000},  // R2 stage high
    {1'b0, 8'h0C, 16'h0000, 16'hFFFF},  // R2 not yet live
    {1'b1, 8'h08, 16'h0034, 16'h0000},  // R2 commit
    {1'b0, 8'h0C, 16'h0000, 16'h0012},  // R2
    {1'b0, 8'h08, 16'h0000, 16'h0034},  // R2
    {1'b1, 8'h10, 16'h0001, 16'h0000},  // R1 enable write
    {1'b0, 8'h10, 16'h0000, 16'h0001}   // R1 enable readback
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_per = 1'b1;
  logic          tick_sec = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ivt_timer #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .tick_per(tick_per), .tick_sec(tick_sec),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[AW-1:0];
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual hung expected finished");
    summary();
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 irq after reset", {15'd0, irq}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [TW-1:0] v;
      v = VEC[i];
      if (v[TW-1]) wr(v[2*DW+7 -: 8], v[2*DW-1 -: DW]);
      else begin
        rd(v[2*DW+7 -: 8], d);
        chk($sformatf("R1/R2 vector %0d", i), d, v[DW-1:0]);
      end
    end

    // R4: prescaler P=3 over 40 ticks, period 0x00120034
    wr(8'h04, 16'h0301); wr(8'h00, 16'h0100); wr(8'h00, 16'h0001);
    repeat (40) @(negedge clk);
    rd(8'h20, d); chk("R4 divide by 4", d, 16'd10);
    wr(8'h04, 16'h0001); wr(8'h00, 16'h0100); wr(8'h00, 16'h0001);
    repeat (40) @(negedge clk);
    rd(8'h20, d); chk("R4 divide by 1", d, 16'd40);

    // R5: secondary source, peripheral tick held high but not selected
    wr(8'h04, 16'h0009); wr(8'h00, 16'h0100); wr(8'h00, 16'h0001);
    for (int p = 0; p < 7; p++) begin
      tick_sec = 1'b1; @(negedge clk);
      tick_sec = 1'b0; @(negedge clk); @(negedge clk);
    end
    rd(8'h20, d); chk("R5 secondary ticks only", d, 16'd7);

    // R7: one-shot with period 5
    wr(8'h0C, 16'h0000); wr(8'h08, 16'h0005);
    wr(8'h04, 16'h0000); wr(8'h10, 16'h0001);
    wr(8'h00, 16'h0100); wr(8'h00, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R9 irq before hit", {15'd0, irq}, 16'd0);
    repeat (20) @(negedge clk);
    chk("R9 irq after hit", {15'd0, irq}, 16'd1);
    rd(8'h20, d); chk("R7 stops at period", d, 16'd5);
    rd(8'h00, d); chk("R7 running cleared", d, 16'd0);
    rd(8'h1C, d); chk("R8 status pending", d, 16'd1);
    chk("R9 irq cleared by read", {15'd0, irq}, 16'd0);
    rd(8'h1C, d); chk("R8 status cleared", d, 16'd0);
    wr(8'h00, 16'h0001);
    repeat (2) @(negedge clk);
    rd(8'h20, d); chk("R7 restart from zero", d, 16'd2);

    // R6: continuous with period 4 wraps every 5 advances
    wr(8'h08, 16'h0004); wr(8'h04, 16'h0001);
    wr(8'h00, 16'h0100); wr(8'h00, 16'h0001);
    repeat (12) @(negedge clk);
    rd(8'h20, d); chk("R6 wrapped count", d, 16'd2);
    rd(8'h1C, d); chk("R6 flag on hit", d, 16'd1);

    // R9: enable off masks the line, flag still visible
    wr(8'h10, 16'h0000);
    rd(8'h1C, d);
    repeat (20) @(negedge clk);
    chk("R9 masked irq", {15'd0, irq}, 16'd0);
    rd(8'h1C, d); chk("R8 flag while masked", d, 16'd1);
    wr(8'h10, 16'h0001);
    repeat (6) @(negedge clk);
    chk("R9 irq when enabled", {15'd0, irq}, 16'd1);

    // R3: software reset while running
    wr(8'h00, 16'h0100);
    chk("R3 irq cleared by reset", {15'd0, irq}, 16'd0);
    repeat (10) @(negedge clk);
    rd(8'h20, d); chk("R3 counter cleared", d, 16'd0);
    rd(8'h00, d); chk("R3 stopped", d, 16'd0);
    rd(8'h1C, d); chk("R3 status cleared", d, 16'd0);
    rd(8'h04, d); chk("R3 mode kept", d, 16'h0001);
    rd(8'h08, d); chk("R3 period kept", d, 16'h0004);
    rd(8'h10, d); chk("R3 enable kept", d, 16'h0001);
    wr(8'h00, 16'h0101);
    repeat (5) @(negedge clk);
    rd(8'h00, d); chk("R3 reset wins over start", d, 16'd0);
    rd(8'h20, d); chk("R3 no count after both bits", d, 16'd0);

    // R10: carry into the high half between the two reads
    wr(8'h0C, 16'hFFFF); wr(8'h08, 16'hFFFF); wr(8'h04, 16'h0001);
    wr(8'h00, 16'h0100); wr(8'h00, 16'h0001);
    repeat (65400) @(negedge clk);
    rd(8'h20, d); chk("R10 low before carry", d, 16'hFF78);
    repeat (400) @(negedge clk);
    rd(8'h24, d); chk("R10 high from shadow", d, 16'h0000);
    rd(8'h20, d); chk("R10 low after carry", d, 16'h010A);
    rd(8'h24, d); chk("R10 high after carry", d, 16'h0001);

    summary();
  end
endmodule